// File: doc/BRIEF.md
# Programmable Tick Timer with Match Modes

The block is a processor tick timer. A 32-bit count register advances by one on every cycle where a tick-enable strobe is high. A 32-bit control register holds a 28-bit period, an interrupt-enable flag, an interrupt-pending flag and a 2-bit mode. When a tick carries the low 28 bits of the count onto the programmed period, a match occurs. On a match the timer can raise an interrupt. The mode then decides what happens to the count: it is forced back to zero, it stops, it keeps running, or the timer is idle.

Software reaches both registers through a small synchronous port. The port has a write strobe, a one-bit register select and a 32-bit write word. The read word is combinational and follows the select. Software clears the pending flag by writing the control register with that flag at zero. The tick strobe comes from the system clock domain, for example one pulse every 50 ns for a 20 MHz tick rate.

Top module: `tick_timer`

## Requirements
- R1: While reset is asserted and after it is released, the count reads 0, the control register reads 0 and irq_o is low.
- R2: While the mode is not 00 and the timer is not halted, the count rises by exactly one on each cycle where tick_en_i is high. On cycles where tick_en_i is low the count holds.
- R3: A write with reg_addr_i = 0 loads the count from reg_wdata_i in that cycle, in any mode, and wins over a tick. Counting then continues from the loaded value.
- R4: A match occurs when a tick makes bits [27:0] of the incremented count equal to the period field. Count bits [31:28] take no part in the match.
- R5: On a match with the interrupt-enable bit (bit 29) set, the pending bit (bit 28) becomes 1. On a match with enable clear, the pending bit is left unchanged.
- R6: The pending bit stays at 1 until a control write (reg_addr_i = 1) carries bit 28 = 0. irq_o is high exactly when the pending and enable bits are both 1.
- R7: With mode 00 (bits [31:30]) the count never advances and no match occurs.
- R8: With mode 01, the tick that produces a match loads the count with 0 instead of the incremented value.
- R9: With mode 10, the matching tick stores the incremented value and the count then holds. Any later control write with a mode other than 00 resumes counting.
- R10: With mode 11, the count keeps running through a match. The next match comes when bits [27:0] reach the period again.
- R11: With reg_addr_i = 0, reg_rdata_o shows the count. With reg_addr_i = 1, it shows {mode, enable, pending, period} in bits [31:30], [29], [28] and [27:0].
- R12: When a control write lands in the same cycle as a match, the match is judged with the settings from before the write. The new pending bit is the written bit 28 ORed with the match-set condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, synchronised internally before release |
| tick_en_i | input | 1 | One-cycle tick strobe in the clk_i domain |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register select: 0 count, 1 control |
| reg_wdata_i | input | 32 | Write word |
| reg_rdata_o | output | 32 | Read word of the selected register |
| irq_o | output | 1 | Timer interrupt, level |

## Verification
The assertions take the following as given:
- tick_en_i, reg_we_i and reg_addr_i are clean single-clock-domain levels, never unknown after reset.
- A write carries only one target per cycle.

The bench drives every input on the falling clock edge and holds it for a full cycle. Because the select is a single bit, two targets cannot be written at once. Random periods are kept small and count loads are placed near the period, including values with nonzero upper bits, so matches in every mode occur often. Directed steps set up the same-cycle control write and match.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  typedef enum logic [1:0] {
    TM_OFF     = 2'b00,
    TM_RESTART = 2'b01,
    TM_ONESHOT = 2'b10,
    TM_FREE    = 2'b11
  } tm_mode_e;
endpackage

// File: rtl/tt_compare.sv
module tt_compare #(
  parameter int CNT_W = 32,
  parameter int PER_W = 28
) (
  input  logic [CNT_W-1:0] count_i,
  input  logic [PER_W-1:0] period_i,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             load_i,
  output logic [CNT_W-1:0] inc_o,
  output logic             hit_o
);
  always_comb begin
    inc_o = count_i + CNT_W'(1);
    // only the period-width low bits take part in the match
    hit_o = run_i && tick_i && !load_i && (inc_o[PER_W-1:0] == period_i);
  end
endmodule

// File: rtl/tt_counter.sv
module tt_counter
  import tick_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             hit_i,
  input  tm_mode_e         mode_i,
  input  logic [CNT_W-1:0] inc_i,
  output logic [CNT_W-1:0] count_o
);
  logic [CNT_W-1:0] count_q, count_d;
  logic             count_en;

  always_comb begin
    count_en = 1'b0;
    count_d  = count_q;
    if (wr_en_i) begin
      count_en = 1'b1;
      count_d  = wdata_i;
    end else if (hit_i && (mode_i == TM_RESTART)) begin
      count_en = 1'b1;
      count_d  = '0;
    end else if (run_i && tick_i) begin
      count_en = 1'b1;
      count_d  = inc_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
    end else if (count_en) begin
      count_q <= count_d;
    end
  end

  assign count_o = count_q;

  AST_RESTART_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i && mode_i == TM_RESTART && !wr_en_i) |=> (count_q == '0)); // R8
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !wr_en_i) |=> $stable(count_q)); // R7
  AST_STEP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && tick_i && !wr_en_i && !(hit_i && mode_i == TM_RESTART))
      |=> (count_q == $past(count_q) + CNT_W'(1))); // R2
  AST_LOAD_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (count_q == $past(wdata_i))); // R3
endmodule

// File: rtl/tt_ctrl_reg.sv
module tt_ctrl_reg
  import tick_timer_pkg::*;
#(
  parameter int PER_W  = 28,
  localparam int CTRL_W = PER_W + 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [CTRL_W-1:0] wdata_i,
  input  logic              hit_i,
  output logic [PER_W-1:0]  period_o,
  output tm_mode_e          mode_o,
  output logic              run_o,
  output logic              irq_o,
  output logic [CTRL_W-1:0] ctrl_o
);
  localparam int PEND_B = PER_W;
  localparam int IE_B   = PER_W + 1;

  logic [PER_W-1:0] period_q, period_d;
  logic             ie_q, ie_d;
  logic             pend_q, pend_d;
  tm_mode_e         mode_q, mode_d;
  logic             halt_q, halt_d;

  always_comb begin
    period_d = period_q;
    ie_d     = ie_q;
    mode_d   = mode_q;
    halt_d   = halt_q;
    pend_d   = pend_q;
    if (wr_en_i) begin
      period_d = wdata_i[PER_W-1:0];
      ie_d     = wdata_i[IE_B];
      mode_d   = tm_mode_e'(wdata_i[CTRL_W-1:CTRL_W-2]);
      halt_d   = 1'b0;
      pend_d   = wdata_i[PEND_B];
    end else if (hit_i && (mode_q == TM_ONESHOT)) begin
      halt_d   = 1'b1;
    end
    // a match is judged on the settings held before any write
    if (hit_i && ie_q) begin
      pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      period_q <= '0;
      ie_q     <= 1'b0;
      pend_q   <= 1'b0;
      mode_q   <= TM_OFF;
      halt_q   <= 1'b0;
    end else begin
      period_q <= period_d;
      ie_q     <= ie_d;
      pend_q   <= pend_d;
      mode_q   <= mode_d;
      halt_q   <= halt_d;
    end
  end

  assign period_o = period_q;
  assign mode_o   = mode_q;
  assign run_o    = (mode_q != TM_OFF) && !halt_q;
  assign irq_o    = pend_q && ie_q;
  assign ctrl_o   = {mode_q, ie_q, pend_q, period_q};

  AST_PEND_NEEDS_IE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && !pend_q && !(hit_i && ie_q)) |=> !pend_q); // R5
  AST_PEND_FROM_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i && ie_q) |=> pend_q); // R12
  AST_PEND_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !wr_en_i) |=> pend_q); // R6
  AST_ONESHOT_HALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i && mode_q == TM_ONESHOT && !wr_en_i) |=> !run_o); // R9
  AST_RESUME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wdata_i[CTRL_W-1:CTRL_W-2] != 2'b00) |=> run_o); // R9
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PER_W = 28
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_en_i,
  input  logic             reg_we_i,
  input  logic             reg_addr_i,
  input  logic [CNT_W-1:0] reg_wdata_i,
  output logic [CNT_W-1:0] reg_rdata_o,
  output logic             irq_o
);
  localparam int CTRL_W = PER_W + 4;

  logic             rst_meta_q, rst_n;
  logic             cnt_wr, ctrl_wr, run, hit;
  logic [CNT_W-1:0] count, inc;
  logic [PER_W-1:0] period;
  tm_mode_e         mode;
  logic [CTRL_W-1:0] ctrl;
  logic [CNT_W-1:0] ctrl_rd;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_n      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n      <= rst_meta_q;
    end
  end

  assign cnt_wr  = reg_we_i && !reg_addr_i;
  assign ctrl_wr = reg_we_i &&  reg_addr_i;

  tt_compare #(.CNT_W(CNT_W), .PER_W(PER_W)) u_cmp (
    .count_i (count),
    .period_i(period),
    .run_i   (run),
    .tick_i  (tick_en_i),
    .load_i  (cnt_wr),
    .inc_o   (inc),
    .hit_o   (hit)
  );

  tt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .wr_en_i(cnt_wr),
    .wdata_i(reg_wdata_i),
    .run_i  (run),
    .tick_i (tick_en_i),
    .hit_i  (hit),
    .mode_i (mode),
    .inc_i  (inc),
    .count_o(count)
  );

  tt_ctrl_reg #(.PER_W(PER_W)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .wr_en_i (ctrl_wr),
    .wdata_i (reg_wdata_i[CTRL_W-1:0]),
    .hit_i   (hit),
    .period_o(period),
    .mode_o  (mode),
    .run_o   (run),
    .irq_o   (irq_o),
    .ctrl_o  (ctrl)
  );

  always_comb begin
    ctrl_rd = '0;
    ctrl_rd[CTRL_W-1:0] = ctrl;
    reg_rdata_o = reg_addr_i ? ctrl_rd : count;
  end

  AST_RESET_QUIET: assert property (@(posedge clk_i)
    !rst_n |=> (!rst_n || (count == '0 && !irq_o))); // R1
  AST_OFF_NO_HIT: assert property (@(posedge clk_i) disable iff (!rst_n)
    (mode == TM_OFF) |-> !hit); // R7
endmodule

// File: tb/tick_timer_bench.sv
`timescale 1ns/100ps
module tick_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick;
  logic        we;
  logic        addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // reference state
  logic [31:0] m_cnt;
  logic [27:0] m_per;
  logic        m_ie, m_pend, m_halt;
  logic [1:0]  m_mode;

  always #2.5 clk = ~clk;

  tick_timer u_tick_timer (
    .clk_i(clk), .rst_ni(rst_n), .tick_en_i(tick), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [31:0] ctrl_word();
    return {m_mode, m_ie, m_pend, m_per};
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic observe(string tag);
    addr = 1'b0; #0.5;
    check(tag, "count", rdata, m_cnt);
    addr = 1'b1; #0.5;
    check(tag, "ctrl", rdata, ctrl_word());
    check(tag, "irq", {31'd0, irq}, {31'd0, m_pend & m_ie});
  endtask

  task automatic step(logic t, logic w, logic a, logic [31:0] d, string tag);
    logic        run, hit;
    logic [31:0] inc, n_cnt;
    logic        n_pend, n_halt;
    @(negedge clk);
    tick = t; we = w; addr = a; wdata = d;
    run = (m_mode != 2'b00) && !m_halt;
    inc = m_cnt + 32'd1;
    hit = run && t && !(w && !a) && (inc[27:0] == m_per);
    n_cnt = m_cnt;
    if (w && !a) n_cnt = d;
    else if (hit && m_mode == 2'b01) n_cnt = 32'd0;
    else if (run && t) n_cnt = inc;
    n_pend = (w && a) ? d[28] : m_pend;
    if (hit && m_ie) n_pend = 1'b1;
    n_halt = m_halt;
    if (w && a) n_halt = 1'b0;
    else if (hit && m_mode == 2'b10) n_halt = 1'b1;
    @(posedge clk);
    m_cnt = n_cnt; m_pend = n_pend; m_halt = n_halt;
    if (w && a) begin
      m_per = d[27:0]; m_ie = d[29]; m_mode = d[31:30];
    end
    #1;
    observe(tag);
  endtask

  task automatic ticks(int n, string tag);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, 1'b0, 32'd0, tag);
  endtask

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed_dummy;
    seed_dummy = $urandom(32'd1234);
    rst_n = 1'b0; tick = 1'b0; we = 1'b0; addr = 1'b0; wdata = '0;
    m_cnt = '0; m_per = '0; m_ie = 1'b0; m_pend = 1'b0; m_halt = 1'b0; m_mode = 2'b00;
    repeat (3) @(posedge clk);
    #1; observe("R1 in reset");
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1; observe("R1 after release");

    // R7: mode 00 never counts
    ticks(4, "R7");
    step(1'b0, 1'b1, 1'b0, 32'd2, "R3 load in mode 00");
    ticks(3, "R7 after load");

    // R11 layout, mode 01 period 5, enable on
    step(1'b0, 1'b1, 1'b1, {2'b01, 1'b1, 1'b0, 28'd5}, "R11");
    step(1'b0, 1'b0, 1'b0, 32'd0, "R2 no tick hold");
    ticks(2, "R2");
    ticks(1, "R8 R5 restart match");
    ticks(3, "R6 pending held");
    step(1'b0, 1'b1, 1'b1, {2'b01, 1'b1, 1'b0, 28'd5}, "R6 clear");

    // R9 one-shot period 3
    step(1'b0, 1'b1, 1'b0, 32'd0, "R3");
    step(1'b0, 1'b1, 1'b1, {2'b10, 1'b1, 1'b0, 28'd3}, "R9 setup");
    ticks(3, "R9 reach");
    ticks(4, "R9 halted");
    step(1'b0, 1'b1, 1'b1, {2'b10, 1'b0, 1'b0, 28'd3}, "R9 rearm");
    ticks(2, "R9 resumed");

    // R10 / R4: continuous, upper bits ignored
    step(1'b0, 1'b1, 1'b1, {2'b11, 1'b1, 1'b0, 28'd4}, "R10 setup");
    step(1'b0, 1'b1, 1'b0, 32'h1000_0003, "R4 load");
    ticks(2, "R4 R10 match runs on");
    step(1'b0, 1'b1, 1'b1, {2'b11, 1'b1, 1'b0, 28'd4}, "R6 clear");
    step(1'b0, 1'b1, 1'b0, 32'hF000_0003, "R4 load high");
    ticks(1, "R10 second match");

    // R5 negative: enable clear
    step(1'b0, 1'b1, 1'b1, {2'b01, 1'b0, 1'b0, 28'd2}, "R5 setup");
    step(1'b0, 1'b1, 1'b0, 32'd1, "R3");
    ticks(1, "R5 no enable");

    // R12: control write in the matching cycle
    step(1'b0, 1'b1, 1'b1, {2'b11, 1'b1, 1'b0, 28'd7}, "R12 setup");
    step(1'b0, 1'b1, 1'b0, 32'd6, "R3");
    step(1'b1, 1'b1, 1'b1, {2'b01, 1'b0, 1'b0, 28'd9}, "R12 write on match");

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom % 100;
      if (r < 6)
        step($urandom % 2 == 0, 1'b1, 1'b1,
             {2'($urandom), 1'($urandom), 1'($urandom), 28'($urandom % 8)}, "R2 R4 R10 random ctrl");
      else if (r < 12)
        step(1'b0, 1'b1, 1'b0, {4'($urandom), 28'($urandom % 8)}, "R3 random load");
      else
        step($urandom % 10 < 6, 1'b0, 1'b0, 32'd0, "R2 R8 R9 random tick");
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule